// File: doc/BRIEF.md
# 100 Mbps Transmit Code-Group Encoder

This block sits between a MAC nibble interface and the serializer of a 100 Mbps copper or fibre line. On every symbol time, marked by a clock enable, it takes one 4-bit nibble together with a frame-valid flag and an error flag. It produces one 5-bit code-group. Between frames the line carries the Idle code-group.

At the start of each frame, the block replaces the first preamble octet with a start-of-stream pair. It then maps the remaining preamble, the frame delimiter, the payload and the checksum nibbles through the 4B/5B table. When the frame-valid flag drops, it appends an end-of-stream pair before it returns to Idle.

The output is registered. A code-group chosen from the inputs sampled on an enabled clock edge appears on `symOut` right after that edge and is held until the next enabled edge. Scrambling, line coding, serialization and the receive direction belong to other blocks.

Top module: `pcs_tx_encoder`

## Requirements
- R1: While `rst` is high on a clock edge, the block goes to its between-frames state and `symOut` becomes Idle (11111), whatever `symEn` is. After release, Idle stays until a frame starts.
- R2: Outside a frame, and on each enabled edge where `txEn` is low, `symOut` becomes Idle (11111).
- R3: When `txEn` is high on an enabled edge outside a frame, `symOut` becomes J (11000). On the next enabled edge it becomes K (10001). The two nibbles presented on those edges are dropped, and so are `txEn` and `txErr` on the K edge.
- R4: After K, on each enabled edge with `txEn` high and `txErr` low, `symOut` becomes the 4B/5B code of `txData`. The codes for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: In a frame after K, the first enabled edge with `txEn` low gives T (01101). The next enabled edge gives R (00111), and the inputs on that edge are ignored.
- R6: If `txEn` is high on the enabled edge right after R, that edge gives J, so back-to-back frames keep the full T, R, J, K order. Otherwise that edge gives Idle.
- R7: In a frame after K, when `txEn` and `txErr` are both high on an enabled edge, `symOut` becomes H (00100) in place of the data code. `txErr` has no effect outside that window.
- R8: On a clock edge with `symEn` low and `rst` low, `symOut` and the frame position stay unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| symEn | input | 1 | Symbol-time enable, one pulse per code-group |
| txEn | input | 1 | Frame-valid flag from the MAC |
| txData | input | 4 | Transmit nibble |
| txErr | input | 1 | Transmit error flag |
| symOut | output | 5 | Registered output code-group |

## Verification
Two functions can meet on the same enabled edge. The end-of-stream R can be emitted while the MAC already presents the first nibble of the next frame. The error substitution can also fall on the nibble where the frame ends or on the K edge.

The bench provokes the first case with back-to-back frames separated by a single low `txEn` symbol. It provokes the second by raising `txErr` on dropped preamble nibbles, on payload nibbles and during gaps. A queue-based reference model predicts each code-group, and any misplaced J, lost R or stray H is flagged on the cycle where it appears.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;

  localparam int NIB_W   = 4;
  localparam int SYM_W   = 5;
  localparam int NIB_CNT = 1 << NIB_W;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NIB_W-1:0] nib_t;

  // Control code-groups
  localparam sym_t CG_IDLE = 5'b11111;
  localparam sym_t CG_J    = 5'b11000;
  localparam sym_t CG_K    = 5'b10001;
  localparam sym_t CG_T    = 5'b01101;
  localparam sym_t CG_R    = 5'b00111;
  localparam sym_t CG_H    = 5'b00100;

  // Position within the outgoing stream
  typedef enum logic [1:0] {
    ST_GAP   = 2'd0,
    ST_SSD_K = 2'd1,
    ST_BODY  = 2'd2,
    ST_ESD_R = 2'd3
  } txState_e;

  // Which code-group the datapath loads
  typedef enum logic [2:0] {
    SEL_IDLE = 3'd0,
    SEL_J    = 3'd1,
    SEL_K    = 3'd2,
    SEL_DATA = 3'd3,
    SEL_ERR  = 3'd4,
    SEL_T    = 3'd5,
    SEL_R    = 3'd6
  } symSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;
    symSel_e sel;
  } txStrobe_t;

  function automatic sym_t encode4b5b(input nib_t nib);
    sym_t code;
    case (nib)
      4'h0: code = 5'b11110;
      4'h1: code = 5'b01001;
      4'h2: code = 5'b10100;
      4'h3: code = 5'b10101;
      4'h4: code = 5'b01010;
      4'h5: code = 5'b01011;
      4'h6: code = 5'b01110;
      4'h7: code = 5'b01111;
      4'h8: code = 5'b10010;
      4'h9: code = 5'b10011;
      4'hA: code = 5'b10110;
      4'hB: code = 5'b10111;
      4'hC: code = 5'b11010;
      4'hD: code = 5'b11011;
      4'hE: code = 5'b11100;
      default: code = 5'b11101;
    endcase
    return code;
  endfunction

  function automatic logic isDataCode(input sym_t s);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NIB_CNT; i++) begin
      if (encode4b5b(NIB_W'(i)) == s) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/pcs_tx_ctrl.sv
module pcs_tx_ctrl
  import pcs_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      symEn,
  input  logic      txEn,
  input  logic      txErr,
  output txStrobe_t strobe
);

  txState_e state, nextState;
  symSel_e  sel;

  always_comb begin
    nextState = state;
    sel       = SEL_IDLE;
    case (state)
      ST_GAP: begin
        if (txEn) begin
          sel       = SEL_J;
          nextState = ST_SSD_K;
        end
      end
      ST_SSD_K: begin
        sel       = SEL_K;
        nextState = ST_BODY;
      end
      ST_BODY: begin
        if (txEn) begin
          sel = txErr ? SEL_ERR : SEL_DATA;
        end else begin
          sel       = SEL_T;
          nextState = ST_ESD_R;
        end
      end
      ST_ESD_R: begin
        sel       = SEL_R;
        nextState = ST_GAP;
      end
      default: begin
        sel       = SEL_IDLE;
        nextState = ST_GAP;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_GAP;
    end else if (symEn) begin
      state <= nextState;
    end
  end

  assign strobe.load = symEn;
  assign strobe.sel  = sel;

endmodule

// File: rtl/pcs_tx_datapath.sv
module pcs_tx_datapath
  import pcs_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  txStrobe_t strobe,
  input  nib_t      txData,
  output sym_t      symOut
);

  sym_t codeRom [NIB_CNT];
  sym_t nextSym;
  sym_t symReg;

  for (genvar g = 0; g < NIB_CNT; g++) begin : g_rom
    assign codeRom[g] = encode4b5b(NIB_W'(g));
  end

  always_comb begin
    case (strobe.sel)
      SEL_J:    nextSym = CG_J;
      SEL_K:    nextSym = CG_K;
      SEL_DATA: nextSym = codeRom[txData];
      SEL_ERR:  nextSym = CG_H;
      SEL_T:    nextSym = CG_T;
      SEL_R:    nextSym = CG_R;
      default:  nextSym = CG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      symReg <= CG_IDLE;
    end else if (strobe.load) begin
      symReg <= nextSym;
    end
  end

  assign symOut = symReg;

endmodule

// File: rtl/pcs_tx_encoder.sv
module pcs_tx_encoder
  import pcs_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             symEn,
  input  logic             txEn,
  input  logic [NIB_W-1:0] txData,
  input  logic             txErr,
  output logic [SYM_W-1:0] symOut
);

  txStrobe_t strobe;

  pcs_tx_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .symEn  (symEn),
    .txEn   (txEn),
    .txErr  (txErr),
    .strobe (strobe)
  );

  pcs_tx_datapath dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .txData (txData),
    .symOut (symOut)
  );

endmodule

// File: rtl/pcs_tx_encoder_chk.sv
module pcs_tx_encoder_chk
  import pcs_tx_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             symEn,
  input logic             txEn,
  input logic [NIB_W-1:0] txData,
  input logic             txErr,
  input logic [SYM_W-1:0] symOut
);

  logic inBody;
  assign inBody = isDataCode(symOut) || (symOut == CG_K) || (symOut == CG_H);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $fell(rst) |-> symOut == CG_IDLE);

  // R2
  gap_idle_chk: assert property (@(posedge clk) disable iff (rst)
    symEn && !txEn && (symOut == CG_IDLE || symOut == CG_R) |=> symOut == CG_IDLE);

  // R3
  j_then_k_chk: assert property (@(posedge clk) disable iff (rst)
    symEn && symOut == CG_J |=> symOut == CG_K);

  // R4
  data_map_chk: assert property (@(posedge clk) disable iff (rst)
    symEn && txEn && !txErr && inBody |=> symOut == encode4b5b($past(txData)));

  // R5
  body_end_t_chk: assert property (@(posedge clk) disable iff (rst)
    symEn && !txEn && inBody |=> symOut == CG_T);

  // R5
  t_then_r_chk: assert property (@(posedge clk) disable iff (rst)
    symEn && symOut == CG_T |=> symOut == CG_R);

  // R6
  after_r_chk: assert property (@(posedge clk) disable iff (rst)
    symEn && symOut == CG_R |=> symOut == ($past(txEn) ? CG_J : CG_IDLE));

  // R7
  err_subst_chk: assert property (@(posedge clk) disable iff (rst)
    symEn && txEn && txErr && inBody |=> symOut == CG_H);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !symEn |=> $stable(symOut));

endmodule

bind pcs_tx_encoder pcs_tx_encoder_chk chk_i (.*);

// File: tb/pcs_tx_encoder_tb_top.sv
`timescale 1ns/1ps
module pcs_tx_encoder_tb_top;

  localparam logic [4:0] IDLE = 5'b11111, J = 5'b11000, K = 5'b10001,
                         T = 5'b01101, R = 5'b00111, H = 5'b00100;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic symEn = 1'b0;
  logic txEn = 1'b0;
  logic txErr = 1'b0;
  logic [3:0] txData = 4'h0;
  logic [4:0] symOut;

  always #2 clk = ~clk;

  pcs_tx_encoder dut_i (
    .clk(clk), .rst(rst), .symEn(symEn), .txEn(txEn),
    .txData(txData), .txErr(txErr), .symOut(symOut)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // R4 table, written independently
  logic [4:0] refTbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                              5'b01010, 5'b01011, 5'b01110, 5'b01111,
                              5'b10010, 5'b10011, 5'b10110, 5'b10111,
                              5'b11010, 5'b11011, 5'b11100, 5'b11101};

  // Behavioural reference: pending forced symbols plus an in-frame flag
  logic [4:0] pending[$];
  bit inFrame = 0;
  bit ticked = 0;
  bit afterReset = 1;
  logic [4:0] expSym = 5'b11111;
  logic [4:0] prevExp = 5'b11111;

  always @(posedge clk) begin
    ticked = 0;
    if (rst) begin
      pending.delete();
      inFrame = 0;
      expSym = IDLE;
      afterReset = 1;
    end else if (symEn) begin
      ticked = 1;
      prevExp = expSym;
      if (pending.size() > 0) begin
        expSym = pending.pop_front();
      end else if (!inFrame) begin
        if (txEn) begin
          expSym = J;
          pending.push_back(K);
          inFrame = 1;
        end else begin
          expSym = IDLE;
        end
      end else if (txEn) begin
        expSym = txErr ? H : refTbl[txData];
      end else begin
        expSym = T;
        pending.push_back(R);
        inFrame = 0;
      end
    end
  end

  always @(negedge clk) begin
    string tag;
    if (!rst) begin
      if (afterReset) tag = "R1";
      else if (!ticked) tag = "R8";
      else if (expSym == J && prevExp == R) tag = "R6";
      else if (expSym == J || expSym == K) tag = "R3";
      else if (expSym == T || expSym == R) tag = "R5";
      else if (expSym == H) tag = "R7";
      else if (expSym == IDLE) tag = "R2";
      else tag = "R4";
      checks++;
      if (symOut !== expSym) begin
        failures++;
        $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cycles, symOut, expSym);
      end
      afterReset = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog (all requirements): actual=%0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // One symbol time, preceded by `hold` disabled cycles carrying noise (R8)
  task automatic step(input bit en, input logic [3:0] d, input bit err, input int hold);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk); #1;
      symEn = 0;
      txEn = 1'($urandom & 1);
      txData = 4'($urandom);
      txErr = 1'($urandom & 1);
    end
    @(negedge clk); #1;
    symEn = 1; txEn = en; txData = d; txErr = err;
  endtask

  task automatic gap(input int n, input int hold, input bit errNoise);
    for (int i = 0; i < n; i++) step(0, 4'($urandom), errNoise ? 1'($urandom & 1) : 1'b0, hold);
  endtask

  // Preamble incl. replaced octet, SFD, payload, checksum nibbles
  task automatic sendFrame(input int nBytes, input int errNib, input int hold, input bit errOnK);
    for (int i = 0; i < 15; i++) step(1, 4'h5, (i == 1) && errOnK, hold);
    step(1, 4'hD, 0, hold);
    for (int i = 0; i < nBytes * 2; i++) step(1, 4'($urandom), i == errNib, hold);
    for (int i = 0; i < 8; i++) step(1, 4'($urandom), 0, hold);
  endtask

  initial begin
    rst = 1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); #1; symEn = 1'(i & 1); end
    @(negedge clk); #1; rst = 0; symEn = 0;
    gap(6, 0, 0);                  // R1, R2
    sendFrame(8, -1, 0, 1);        // R3 (txErr on K dropped), R4, R5
    gap(20, 0, 1);                 // R7 noise ignored in gap
    sendFrame(4, 5, 0, 0);         // R7 substitution
    gap(1, 0, 0);                  // T, then next frame rises during R
    sendFrame(6, 3, 0, 0);         // R6 back-to-back
    gap(1, 0, 0);
    sendFrame(2, -1, 0, 0);        // R6 again
    gap(3, 0, 0);
    sendFrame(3, -1, 2, 0);        // R8 holds inside a frame
    gap(12, 1, 1);                 // R8 holds in the gap
    step(1, 4'h5, 0, 0);           // minimal frame: J, K, then T, R
    step(1, 4'h5, 1, 0);
    gap(4, 0, 0);
    step(1, 4'h5, 0, 0);           // frame aborted by reset (R1)
    step(1, 4'h5, 0, 0);
    step(1, 4'hA, 0, 0);
    @(negedge clk); #1; rst = 1; symEn = 1; txEn = 1;
    @(negedge clk); #1;
    @(negedge clk); #1; rst = 0; symEn = 0; txEn = 0;
    gap(5, 0, 0);
    sendFrame(2, 0, 1, 0);
    gap(4, 0, 0);
    @(negedge clk); #1; symEn = 0;
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule